// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address. It holds four segment registers: code, data, stack and extra. The segment value is moved up by four bit positions, so each segment begins on a 16-byte boundary. The offset, zero-extended, is then added to it. Any carry beyond the top address bit is dropped, so addresses wrap silently inside the 1 MB space. Because of this, different segment and offset pairs can reach the same byte.

Each access request states which register supplied its offset: instruction pointer, stack pointer, base pointer or a general register. Each source has a default segment. For any source except the instruction pointer, an override selector can replace that default with any of the four segments. A synchronous write port loads the segment registers. The address and the number of the segment used are produced combinationally from the current register contents and the request inputs.

Top module: `seg_addr_gen`

## Requirements
- R1: Synchronous active-high reset clears all four segment registers to 0x0000, so after reset the physical address equals the zero-extended offset.
- R2: When `wr_en` is high at a rising edge, the register named by `wr_sel` takes `wr_data` from that edge on. The other three registers keep their values, and the outputs before that edge still show the old contents.
- R3: `phys_addr` equals (segment value × 16 + zero-extended offset) modulo 2^20. For example, segment 0x1DDD with offset 0x0100 gives 0x1DED0.
- R4: A carry out of bit 19 is discarded. For example, segment 0xFFFF with offset 0xFFFF gives 0x0FFEF.
- R5: With `src` = 0 (instruction pointer), the code segment (number 0) is used and the override inputs have no effect.
- R6: With `src` = 1 (stack pointer) or 2 (base pointer) and `ovr_en` low, the stack segment (number 2) is used.
- R7: With `src` = 3 (general register) and `ovr_en` low, the data segment (number 1) is used.
- R8: With `src` other than 0 and `ovr_en` high, the segment numbered by `ovr_sel` is used (0 code, 1 data, 2 stack, 3 extra).
- R9: `phys_addr` and `seg_used` follow changes on `offset`, `src` and the override inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Register to write (0 code, 1 data, 2 stack, 3 extra) |
| wr_data | input | 16 | Value to write |
| src | input | 2 | Offset source (0 IP, 1 SP, 2 BP, 3 general) |
| ovr_en | input | 1 | Segment override request |
| ovr_sel | input | 2 | Segment chosen by the override |
| offset | input | 16 | Offset value |
| seg_used | output | 2 | Number of the segment applied |
| phys_addr | output | 20 | Physical address |

## Verification
The assertions check the segment choice rules on every cycle. They also check that the low address nibble equals the low offset nibble, that a write lands in its target register, and that registers which are not targeted stay unchanged. The actual sums, including wraparound at the top of the address space and aliasing between different segment and offset pairs, can only be shown by the bench sweeps. These sweeps load several register patterns and compare every source, override and offset combination against arithmetic computed in the bench. The same holds for same-cycle response and the old-contents-before-edge behaviour of the write port.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int SHIFT  = 4;
    localparam int NSEG   = 4;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        SRC_IP  = 2'd0,
        SRC_SP  = 2'd1,
        SRC_BP  = 2'd2,
        SRC_GEN = 2'd3
    } off_src_e;

    typedef struct packed {
        off_src_e src;
        logic     ovr_en;
        seg_id_e  ovr_sel;
    } seg_req_t;

    // Default segment for each offset source
    function automatic seg_id_e default_seg(input off_src_e s);
        case (s)
            SRC_IP:         default_seg = SEG_CODE;
            SRC_SP, SRC_BP: default_seg = SEG_STACK;
            default:        default_seg = SEG_DATA;
        endcase
    endfunction

    // Instruction fetch cannot be redirected
    function automatic logic override_allowed(input off_src_e s);
        override_allowed = (s != SRC_IP);
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int W  = SEG_W,
    parameter int N  = NSEG,
    localparam int SW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_sel,
    input  logic [W-1:0]      wr_data,
    input  logic [SW-1:0]     rd_sel,
    output logic [W-1:0]      rd_data
);

    logic [W-1:0] seg_q [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                seg_q[i] <= '0;
            else if (wr_en && (wr_sel == SW'(i)))
                seg_q[i] <= wr_data;
        end

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == SW'(i)) |=> (seg_q[i] == $past(wr_data))); // R2
        AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_sel == SW'(i)) |=> $stable(seg_q[i])); // R2
        AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (seg_q[i] == '0)); // R1
    end

    assign rd_data = seg_q[rd_sel];

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seg_req_t req,
    output seg_id_e  seg_id
);

    always_comb begin
        if (req.ovr_en && override_allowed(req.src))
            seg_id = req.ovr_sel;
        else
            seg_id = default_seg(req.src);
    end

    AST_IP_CODE: assert property (@(posedge clk) disable iff (rst)
        (req.src == SRC_IP) |-> (seg_id == SEG_CODE)); // R5
    AST_DEFAULT_STACK: assert property (@(posedge clk) disable iff (rst)
        (!req.ovr_en && (req.src == SRC_SP || req.src == SRC_BP)) |-> (seg_id == SEG_STACK)); // R6
    AST_DEFAULT_DATA: assert property (@(posedge clk) disable iff (rst)
        (!req.ovr_en && req.src == SRC_GEN) |-> (seg_id == SEG_DATA)); // R7
    AST_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        (req.ovr_en && req.src != SRC_IP) |-> (seg_id == req.ovr_sel)); // R8

endmodule

// File: rtl/addr_adder.sv
module addr_adder
    import seg_addr_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int OW = OFF_W,
    parameter int SH = SHIFT,
    localparam int PA_W = SW + SH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SW-1:0]   seg_val,
    input  logic [OW-1:0]   off_val,
    output logic [PA_W-1:0] phys
);

    logic [PA_W-1:0] base;
    logic [PA_W-1:0] off_ext;

    assign base    = {seg_val, {SH{1'b0}}};
    assign off_ext = PA_W'(off_val);
    // Sum kept to PA_W bits: the carry past the top bit is dropped
    assign phys    = base + off_ext;

    AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        phys[SH-1:0] == off_val[SH-1:0]); // R3

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [1:0]  src,
    input  logic        ovr_en,
    input  logic [1:0]  ovr_sel,
    input  logic [15:0] offset,
    output logic [1:0]  seg_used,
    output logic [19:0] phys_addr
);

    seg_req_t          req;
    seg_id_e           seg_id;
    logic [SEG_W-1:0]  seg_val;

    assign req.src     = off_src_e'(src);
    assign req.ovr_en  = ovr_en;
    assign req.ovr_sel = seg_id_e'(ovr_sel);

    seg_select u_sel (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .seg_id (seg_id)
    );

    seg_regfile #(.W(SEG_W), .N(NSEG)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (seg_id),
        .rd_data (seg_val)
    );

    addr_adder #(.SW(SEG_W), .OW(OFF_W), .SH(SHIFT)) u_add (
        .clk     (clk),
        .rst     (rst),
        .seg_val (seg_val),
        .off_val (offset),
        .phys    (phys_addr)
    );

    assign seg_used = seg_id;

endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  src = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic [15:0] offset = '0;
    logic [1:0]  seg_used;
    logic [19:0] phys_addr;

    int checks = 0;
    int failures = 0;
    logic [15:0] model [4];
    logic [15:0] offs [6];

    always #4 clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .src(src), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .offset(offset),
        .seg_used(seg_used), .phys_addr(phys_addr)
    );

    function automatic logic [1:0] exp_seg(input logic [1:0] s, input logic o, input logic [1:0] os);
        if (s == 2'd0) return 2'd0;
        if (o) return os;
        if (s == 2'd1 || s == 2'd2) return 2'd2;
        return 2'd1;
    endfunction

    function automatic logic [19:0] exp_pa(input logic [15:0] sg, input logic [15:0] of);
        logic [20:0] full;
        full = {1'b0, sg, 4'h0} + {5'h0, of};
        return full[19:0];
    endfunction

    task automatic check(input string req, input logic [1:0] es, input logic [19:0] ea);
        checks++;
        if (seg_used !== es || phys_addr !== ea) begin
            failures++;
            $display("FAIL %s: seg=%0d addr=%05h expected seg=%0d addr=%05h",
                     req, seg_used, phys_addr, es, ea);
        end
    endtask

    task automatic apply(input logic [1:0] s, input logic o, input logic [1:0] os, input logic [15:0] of);
        src = s; ovr_en = o; ovr_sel = os; offset = of;
        #1;
    endtask

    task automatic write_seg(input logic [1:0] sel, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model[sel] = v;
    endtask

    task automatic sweep(input string tag);
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 2; o++)
                for (int os = 0; os < 4; os++)
                    for (int k = 0; k < 6; k++) begin
                        logic [1:0] es;
                        apply(2'(s), o[0], 2'(os), offs[k]);
                        es = exp_seg(2'(s), o[0], 2'(os));
                        check(tag, es, exp_pa(model[es], offs[k]));
                    end
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'h0100;
        offs[3] = 16'h7FFF; offs[4] = 16'hFFF0; offs[5] = 16'hFFFF;
        for (int i = 0; i < 4; i++) model[i] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: all segments zero after reset
        for (int s = 0; s < 4; s++) begin
            apply(2'(s), 1'b0, 2'd0, 16'h1234);
            check("R1", exp_seg(2'(s), 1'b0, 2'd0), 20'h01234);
        end
        apply(2'd3, 1'b1, 2'd3, 16'hABCD);
        check("R1", 2'd3, 20'h0ABCD);

        write_seg(2'd0, 16'h1DDD);
        write_seg(2'd1, 16'h1DCD);
        write_seg(2'd2, 16'h1DED);
        write_seg(2'd3, 16'hFFFF);

        // R3 and R5: example address through instruction fetch
        apply(2'd0, 1'b0, 2'd0, 16'h0100);
        check("R3", 2'd0, 20'h1DED0);
        // R7: aliasing pair via data segment
        apply(2'd3, 1'b0, 2'd0, 16'h0200);
        check("R7", 2'd1, 20'h1DED0);
        // R6: stack pointer and base pointer default to stack
        apply(2'd1, 1'b0, 2'd0, 16'h0000);
        check("R6", 2'd2, 20'h1DED0);
        apply(2'd2, 1'b0, 2'd0, 16'h0005);
        check("R6", 2'd2, 20'h1DED5);
        // R4: wraparound past 1 MB
        apply(2'd3, 1'b1, 2'd3, 16'hFFFF);
        check("R4", 2'd3, 20'h0FFEF);
        apply(2'd1, 1'b1, 2'd3, 16'h0010);
        check("R4", 2'd3, 20'h00000);
        // R5: override ignored for instruction pointer
        apply(2'd0, 1'b1, 2'd3, 16'h0100);
        check("R5", 2'd0, 20'h1DED0);
        // R8: override picks each segment
        apply(2'd3, 1'b1, 2'd2, 16'h0000);
        check("R8", 2'd2, 20'h1DED0);
        apply(2'd1, 1'b1, 2'd0, 16'h0000);
        check("R8", 2'd0, 20'h1DDD0);

        // R9: same-cycle response to offset change with no edge
        @(negedge clk);
        apply(2'd3, 1'b0, 2'd0, 16'h0001);
        check("R9", 2'd1, 20'h1DCD1);
        apply(2'd3, 1'b0, 2'd0, 16'h0002);
        check("R9", 2'd1, 20'h1DCD2);
        apply(2'd2, 1'b0, 2'd0, 16'h0002);
        check("R9", 2'd2, 20'h1DED2);

        // R2: old value visible before the edge, new after it
        @(negedge clk);
        apply(2'd3, 1'b0, 2'd0, 16'h0000);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h4000;
        #1;
        check("R2", 2'd1, 20'h1DCD0);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model[1] = 16'h4000;
        check("R2", 2'd1, 20'h40000);
        // R2: other registers untouched by that write
        sweep("R2");

        // R3: full sweeps over several register patterns
        write_seg(2'd0, 16'h0000); write_seg(2'd1, 16'h8001);
        write_seg(2'd2, 16'hF000); write_seg(2'd3, 16'h1234);
        sweep("R3");
        write_seg(2'd0, 16'hFFF1); write_seg(2'd1, 16'hA5A5);
        write_seg(2'd2, 16'h0FFF); write_seg(2'd3, 16'hF00F);
        sweep("R8");

        // R1: reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) model[i] = '0;
        sweep("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule